// File: doc/BRIEF.md
# Single-Channel Memory Copy Engine

This block is one channel of a memory-to-memory copy engine on a simple valid/ready bus. Software loads a source address, a destination address and an element count, then writes a control word that picks the transfer mode, the stepping of each address, the element width, reload and null-write behaviour, a software start bit and the channel enable. A hardware trigger pulse, or the software start bit, starts the work. For each element the engine reads from the source, writes the captured data to the destination and, if asked, adds a dummy write back to the source. It then steps both addresses and lowers the count.

The programmed source, destination and count are also kept in private copies. These let a later start restore them. A one-cycle done pulse marks the point where the count runs out. Repeated modes then restore the count and stay armed. Non-repeated modes switch the channel off.

Control word bits: [0] enable, [1] byte size, [3:2] transfer mode, [5:4] destination step, [7:6] source step, [8] software start, [9] reload, [10] null write.

Top module: `dma_channel`

## Requirements
- R1: After reset the control word reads 0, `bus_valid` is low and `done` is low.
- R2: While control bit 0 (enable) is 0, neither a trigger pulse nor control bit 8 starts any bus transaction, and the count is unchanged.
- R3: Each element is a read at the source address (`bus_we`=0), then a write of the read data at the destination address (`bus_we`=1). With control bit 1 = 1 the element is a byte: `bus_byte`=1, and only the low 8 read bits are carried, with the upper 8 bits written as 0. With bit 1 = 0 it is a 16-bit word.
- R4: After each element, a step field (source in bits [7:6], destination in bits [5:4]) of 01 adds the step and 10 subtracts it, modulo 2^AW. A field of 00 or 11 leaves the address as it was. The step is 1 for bytes and 2 for words.
- R5: Control bits [3:2] encode the mode: 00 one-shot, 01 repeated one-shot, 10 continuous, 11 repeated continuous. With bit 3 = 0 each start moves one element. With bit 3 = 1 one start moves every remaining element back to back.
- R6: When the count reaches zero with bit 2 = 0, `done` is high for exactly one cycle and control bits 0 and 8 are cleared.
- R7: When the count reaches zero with bit 2 = 1, `done` pulses, the count returns to its programmed value and enable stays 1.
- R8: With control bit 9 = 1, the first start after a completion restores the source, destination and count to their programmed values. Until that start they keep their final values. With bit 9 = 0 the next run continues from the final addresses.
- R9: With control bit 10 = 1, each destination write is followed by one more write, with the same data, at that element's source address before stepping.
- R10: Control bit 8 starts work just as a trigger does. The engine clears it when it returns to idle: after one element in one-shot modes, or after the whole block in continuous modes.
- R11: While `bus_valid` is high and `bus_ready` is low, `bus_addr`, `bus_we`, `bus_byte` and, for writes, `bus_wdata` hold steady.
- R12: A start request has no effect when the count is zero and no reload is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| set_we | input | 1 | Load source, destination and count (and their private copies) |
| set_src | input | AW | Source address to load |
| set_dst | input | AW | Destination address to load |
| set_cnt | input | CW | Element count to load |
| ctrl_we | input | 1 | Load the control word |
| ctrl_wdata | input | 11 | Control word to load |
| trig | input | 1 | Hardware start pulse |
| bus_valid | output | 1 | Bus request valid |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_byte | output | 1 | 1 for byte access, 0 for 16-bit word |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, valid with `bus_ready` on a read |
| bus_ready | input | 1 | Request accepted this cycle |
| ctrl_q | output | 11 | Current control word |
| src_q | output | AW | Current source address |
| dst_q | output | AW | Current destination address |
| cnt_q | output | CW | Current remaining count |
| done | output | 1 | One-cycle pulse when the count runs out |

## Verification
The bench builds the engine with AW=8 and CW=8, so the whole address space is a 256-byte bench memory. That makes the decrement wrap below address zero a reachable case. The bench also brings in a bus that can hold off `bus_ready` for a chosen number of cycles, so the hold rule is exercised under real stalls. Each run is checked against the requirements through the memory contents, a log of write addresses and data, a handshake count and the readback of the addresses, count and control word.

// File: rtl/dma_channel.sv
module dma_channel #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_we,
  input  logic [AW-1:0] set_src,
  input  logic [AW-1:0] set_dst,
  input  logic [CW-1:0] set_cnt,
  input  logic          ctrl_we,
  input  logic [10:0]   ctrl_wdata,
  input  logic          trig,
  output logic          bus_valid,
  output logic          bus_we,
  output logic          bus_byte,
  output logic [AW-1:0] bus_addr,
  output logic [15:0]   bus_wdata,
  input  logic [15:0]   bus_rdata,
  input  logic          bus_ready,
  output logic [10:0]   ctrl_q,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q,
  output logic [CW-1:0] cnt_q,
  output logic          done
);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_NW} st_t;

  st_t           st;
  logic [10:0]   ctrl;
  logic [AW-1:0] src, dst, src_org, dst_org;
  logic [CW-1:0] cnt, cnt_org;
  logic [15:0]   buf_q;
  logic          rearm;

  wire en    = ctrl[0];
  wire bsz   = ctrl[1];
  wire rpt   = ctrl[2];
  wire cont  = ctrl[3];
  wire swr   = ctrl[8];
  wire rld   = ctrl[9];
  wire nullw = ctrl[10];

  wire [AW-1:0] step    = bsz ? AW'(1) : AW'(2);
  wire [CW-1:0] eff_cnt = (rearm && rld) ? cnt_org : cnt;
  wire          start   = (st == S_IDLE) && en && (trig || swr) && (eff_cnt != '0);
  wire          last    = bus_ready && ((st == S_WR && !nullw) || st == S_NW);
  wire [CW-1:0] cnt_nx  = cnt - CW'(1);

  function automatic logic [AW-1:0] stepped(input logic [AW-1:0] a, input logic [1:0] m,
                                            input logic [AW-1:0] s);
    case (m)
      2'b01:   return a + s;
      2'b10:   return a - s;
      default: return a;
    endcase
  endfunction

  assign bus_valid = (st != S_IDLE);
  assign bus_we    = (st == S_WR) || (st == S_NW);
  assign bus_byte  = bsz;
  assign bus_addr  = (st == S_WR) ? dst : src;
  assign bus_wdata = buf_q;
  assign ctrl_q    = ctrl;
  assign src_q     = src;
  assign dst_q     = dst;
  assign cnt_q     = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ctrl    <= '0;
      src     <= '0;
      dst     <= '0;
      cnt     <= '0;
      src_org <= '0;
      dst_org <= '0;
      cnt_org <= '0;
      buf_q   <= '0;
      rearm   <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (set_we) begin
        src     <= set_src;
        dst     <= set_dst;
        cnt     <= set_cnt;
        src_org <= set_src;
        dst_org <= set_dst;
        cnt_org <= set_cnt;
        rearm   <= 1'b0;
      end
      if (ctrl_we) ctrl <= ctrl_wdata;

      case (st)
        S_IDLE: if (start) begin
          if (rearm && rld) begin
            src <= src_org;
            dst <= dst_org;
            cnt <= cnt_org;
          end
          rearm <= 1'b0;
          st    <= S_RD;
        end
        S_RD: if (bus_ready) begin
          buf_q <= bsz ? {8'h00, bus_rdata[7:0]} : bus_rdata;
          st    <= S_WR;
        end
        S_WR: if (bus_ready && nullw) st <= S_NW;
        default: ;
      endcase

      if (last) begin
        src <= stepped(src, ctrl[7:6], step);
        dst <= stepped(dst, ctrl[5:4], step);
        if (cnt_nx == '0) begin
          done    <= 1'b1;
          rearm   <= 1'b1;
          cnt     <= rpt ? cnt_org : '0;
          ctrl[8] <= 1'b0;
          if (!rpt) ctrl[0] <= 1'b0;
          st      <= S_IDLE;
        end else begin
          cnt <= cnt_nx;
          if (cont) st <= S_RD;
          else begin
            ctrl[8] <= 1'b0;
            st      <= S_IDLE;
          end
        end
      end
    end
  end

endmodule

// File: rtl/dma_channel_chk.sv
module dma_channel_chk #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_valid,
  input logic          bus_we,
  input logic          bus_byte,
  input logic [AW-1:0] bus_addr,
  input logic [15:0]   bus_wdata,
  input logic          bus_ready,
  input logic [10:0]   ctrl_q,
  input logic [CW-1:0] cnt_q,
  input logic          done
);

  assert_bus_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_we)
                                && $stable(bus_byte) && (!bus_we || $stable(bus_wdata)));

  assert_read_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_valid) |-> !bus_we);

  assert_off_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid && !ctrl_q[0] |=> !bus_valid);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done && !ctrl_q[2] |-> !ctrl_q[0] && !ctrl_q[8]);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_repeat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done && ctrl_q[2] |-> ctrl_q[0] && cnt_q != '0);

endmodule

bind dma_channel dma_channel_chk #(.AW(AW), .CW(CW)) u_chk (.*);

// File: tb/sim_dma_channel.sv
`timescale 1ns/1ps
module sim_dma_channel;
  localparam int AW = 8;
  localparam int CW = 8;
  localparam int EN = 1, BYTE = 2, RPT = 4, CONT = 8;
  localparam int D_INC = 16, D_DEC = 32, D_FIX = 48;
  localparam int S_INC = 64, S_DEC = 128;
  localparam int SWR = 256, RLD = 512, NUL = 1024;

  logic clk = 0, rst_n = 0;
  logic set_we = 0, ctrl_we = 0, trig = 0;
  logic [AW-1:0] set_src = 0, set_dst = 0;
  logic [CW-1:0] set_cnt = 0;
  logic [10:0] ctrl_wdata = 0;
  logic bus_valid, bus_we, bus_byte, bus_ready, done;
  logic [AW-1:0] bus_addr, src_q, dst_q;
  logic [15:0] bus_wdata, bus_rdata;
  logic [10:0] ctrl_q;
  logic [CW-1:0] cnt_q;

  int total = 0, bad = 0, lat = 0, wcnt = 0, hs = 0, dcnt = 0, wn = 0;
  logic [7:0] mem [256];
  int wlog_a [16];
  int wlog_d [16];
  bit finished = 0;

  always #10 clk = ~clk;

  dma_channel #(.AW(AW), .CW(CW)) u0 (.*);

  function automatic int pat(input int i);
    return (i * 7 + 3) & 8'hFF;
  endfunction

  assign bus_ready = bus_valid && (wcnt >= lat);
  assign bus_rdata = bus_byte ? {8'h00, mem[bus_addr]} : {mem[8'(bus_addr + 1)], mem[bus_addr]};

  always @(posedge clk) begin
    if (rst_n && done) dcnt++;
    if (bus_valid && !bus_ready) wcnt++;
    if (bus_valid && bus_ready) begin
      wcnt = 0;
      hs++;
      if (bus_we) begin
        mem[bus_addr] <= bus_wdata[7:0];
        if (!bus_byte) mem[8'(bus_addr + 1)] <= bus_wdata[15:8];
        if (wn < 16) begin
          wlog_a[wn] = int'(bus_addr);
          wlog_d[wn] = int'(bus_wdata);
        end
        wn++;
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic prog(input int s, input int d, input int c);
    @(negedge clk);
    set_src = AW'(s); set_dst = AW'(d); set_cnt = CW'(c); set_we = 1;
    @(negedge clk);
    set_we = 0;
  endtask

  task automatic setctrl(input int c);
    @(negedge clk);
    ctrl_wdata = 11'(c); ctrl_we = 1;
    @(negedge clk);
    ctrl_we = 0;
  endtask

  task automatic kick(input int wait_cyc);
    @(negedge clk); trig = 1;
    @(negedge clk); trig = 0;
    repeat (wait_cyc) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 ctrl", int'(ctrl_q), 0);
    check("R1 valid", int'(bus_valid), 0);
    check("R1 done", int'(done), 0);
  endtask

  task automatic t_oneshot;
    int d0;
    prog(8'h10, 8'h40, 2);
    setctrl(EN | S_INC | D_INC);
    d0 = dcnt;
    kick(15);
    check("R3 word lo", int'(mem[8'h40]), pat(8'h10));
    check("R3 word hi", int'(mem[8'h41]), pat(8'h11));
    check("R4 src inc", int'(src_q), 8'h12);
    check("R4 dst inc", int'(dst_q), 8'h42);
    check("R5 one elem cnt", int'(cnt_q), 1);
    check("R5 no done yet", dcnt - d0, 0);
    kick(15);
    check("R6 done once", dcnt - d0, 1);
    check("R6 en cleared", int'(ctrl_q[0]), 0);
    check("R6 cnt zero", int'(cnt_q), 0);
    check("R3 second elem", int'(mem[8'h42]), pat(8'h12));
  endtask

  task automatic t_continuous_byte;
    int h0, d0;
    lat = 2;
    prog(8'h22, 8'h60, 3);
    setctrl(EN | BYTE | CONT | S_DEC | D_FIX);
    h0 = hs; d0 = dcnt;
    kick(40);
    check("R5 all elems", hs - h0, 6);
    check("R3 byte last", int'(mem[8'h60]), pat(8'h20));
    check("R3 byte untouched", int'(mem[8'h61]), pat(8'h61));
    check("R4 src dec byte", int'(src_q), 8'h1F);
    check("R4 dst fixed", int'(dst_q), 8'h60);
    check("R6 cont done", dcnt - d0, 1);
    lat = 0;
  endtask

  task automatic t_swreq;
    prog(8'h30, 8'h70, 2);
    setctrl(EN | CONT | SWR | D_INC);
    repeat (20) @(negedge clk);
    check("R10 swreq ran", int'(mem[8'h72]), pat(8'h30));
    check("R10 swreq cleared", int'(ctrl_q[8]), 0);
    check("R4 src keep", int'(src_q), 8'h30);
    check("R4 dst word", int'(dst_q), 8'h74);
  endtask

  task automatic t_disabled;
    int h0;
    prog(8'h10, 8'h80, 1);
    h0 = hs;
    setctrl(S_INC | D_INC | SWR);
    kick(10);
    check("R2 no bus", hs - h0, 0);
    check("R2 cnt kept", int'(cnt_q), 1);
    check("R2 mem kept", int'(mem[8'h80]), pat(8'h80));
    setctrl(0);
  endtask

  task automatic t_repeat_noreload;
    int d0;
    prog(8'h30, 8'h84, 1);
    setctrl(EN | RPT | S_INC | D_INC);
    d0 = dcnt;
    kick(15);
    check("R7 done", dcnt - d0, 1);
    check("R7 cnt restored", int'(cnt_q), 1);
    check("R7 en stays", int'(ctrl_q[0]), 1);
    kick(15);
    check("R8 no reload src", int'(src_q), 8'h34);
    check("R8 no reload dst", int'(dst_q), 8'h88);
    check("R8 second data", int'(mem[8'h86]), pat(8'h32));
  endtask

  task automatic t_repeat_reload;
    prog(8'h50, 8'h90, 2);
    setctrl(EN | RPT | CONT | RLD | S_INC | D_INC);
    kick(20);
    check("R8 src held final", int'(src_q), 8'h54);
    check("R7 cnt back", int'(cnt_q), 2);
    wn = 0;
    kick(20);
    check("R8 restart dst", wlog_a[0], 8'h90);
    check("R8 writes", wn, 2);
    check("R8 src final again", int'(src_q), 8'h54);
  endtask

  task automatic t_single_reload;
    prog(8'h50, 8'hA0, 1);
    setctrl(EN | RLD | S_INC | D_INC);
    kick(15);
    check("R6 off", int'(ctrl_q[0]), 0);
    setctrl(EN | RLD | S_INC | D_INC);
    check("R8 not before start", int'(src_q), 8'h52);
    wn = 0;
    kick(15);
    check("R8 reload dst", wlog_a[0], 8'hA0);
    check("R8 reload src", int'(src_q), 8'h52);
  endtask

  task automatic t_nullw;
    prog(8'h24, 8'hB0, 1);
    setctrl(EN | NUL | BYTE | S_INC | D_INC);
    wn = 0;
    lat = 1;
    kick(20);
    lat = 0;
    check("R9 two writes", wn, 2);
    check("R9 dst first", wlog_a[0], 8'hB0);
    check("R9 src dummy", wlog_a[1], 8'h24);
    check("R3 byte data", wlog_d[0], pat(8'h24));
    check("R4 src after", int'(src_q), 8'h25);
  endtask

  task automatic t_wrap;
    prog(8'h00, 8'hC0, 1);
    setctrl(EN | S_DEC | D_DEC);
    kick(15);
    check("R4 src wrap", int'(src_q), 8'hFE);
    check("R4 dst dec", int'(dst_q), 8'hBE);
  endtask

  task automatic t_zero;
    int h0;
    prog(8'h10, 8'hC8, 0);
    setctrl(EN | S_INC | D_INC);
    h0 = hs;
    kick(10);
    check("R12 zero count idle", hs - h0, 0);
    check("R12 src kept", int'(src_q), 8'h10);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(pat(i));
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_oneshot;
    t_continuous_byte;
    t_swreq;
    t_disabled;
    t_repeat_noreload;
    t_repeat_reload;
    t_single_reload;
    t_nullw;
    t_wrap;
    t_zero;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule